// File: doc/BRIEF.md
# MDIO Slave with Word and Byte Register Spaces

This block is a management-bus slave clocked by the management clock (MDC). It reads the serial frames on the data line (MDIO) and turns each valid read or write into a single access on a simple parallel bus. One bit of the five-bit PHY address chooses between two register spaces. The first holds 16-bit standard PHY registers. The second is a flat space of 128 byte-wide switch registers. In the byte space, the two high PHY-address bits are joined above the five-bit register address to form a 7-bit byte address.

A pair of strap inputs controls access to the byte space. Only when both straps are high can a frame reach it; otherwise every frame goes to the word space. For reads, the block sends a read strobe as soon as the address is known. It captures the returned data during the first turnaround bit, then drives the line for the rest of the frame. For writes, it collects sixteen data bits and issues one write strobe.

Top module: `mdio_dual_map_slave`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive ones sampled on `mdioIn`, followed by the start pair 0 then 1. With 31 or fewer ones, the frame causes no strobe and no drive.
- R2: On a read frame, `mdioOe` stays low in the cycle after the last register-address bit (first turnaround bit). In the next cycle it is high with `mdioOut` = 0. Then, one bit per cycle, MSB first, it drives the 16 read-data bits. It is released in the cycle after bit 0.
- R3: When PHY-address bit 2 is 0, the access goes to the word space (`busSpace` = 0). `busAddr` = {PHY address bits 1:0, register address 4:0}, and PHY address bits 4:3 have no effect. Read data comes from `stdRdData`.
- R4: When both straps are 1 and PHY-address bit 2 is 1, the access goes to the byte space (`busSpace` = 1). `busAddr` = {PHY address bits 4:3, register address 4:0}, and PHY address bits 1:0 have no effect.
- R5: When `strapSel` is not 2'b11, every frame goes to the word space, whatever PHY-address bit 2 holds.
- R6: A byte-space read returns 8'h00 in the high byte and `byteRdData` in the low byte.
- R7: A write frame raises `busWrEn` for exactly one cycle, in the cycle after the last data bit. `busWrData` then carries the 16 bits sent, MSB first. In the byte space the high byte reads 8'h00.
- R8: A read frame raises `busRdEn` for exactly one cycle, in the cycle after the last register-address bit. The two strobes are never high together.
- R9: Opcode 2'b10 is a read and 2'b01 is a write (first bit sent is the MSB). Opcodes 2'b00 and 2'b11 abort the frame with no strobe and no drive. A frame that then follows without a fresh 32-one preamble is ignored.
- R10: While `rstN` is low, `mdioOe`, `busRdEn` and `busWrEn` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all sampling on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| mdioIn | input | 1 | Serial data from the management line |
| mdioOut | output | 1 | Serial data driven during read turnaround and data |
| mdioOe | output | 1 | High while the slave drives the line |
| strapSel | input | 2 | Mode straps; 2'b11 opens the byte space |
| busAddr | output | 7 | Register address for the current access |
| busSpace | output | 1 | 0 = word space, 1 = byte space |
| busRdEn | output | 1 | One-cycle read strobe |
| busWrEn | output | 1 | One-cycle write strobe |
| busWrData | output | 16 | Write data, valid with `busWrEn` |
| stdRdData | input | 16 | Read data returned by the word space |
| byteRdData | input | 8 | Read data returned by the byte space |

## Verification
The hardest case to reach from the ports is a frame that looks well formed but must be ignored. That happens when it follows an aborted opcode with no fresh preamble, or when its preamble is one bit short. The stimulus creates this by running an invalid opcode straight into a complete read frame, and by opening another frame with exactly 31 ones after a zero guard bit. The reference model then expects the lines to stay quiet through every cycle of those frames. The model also expects the next fully preambled frame to be served.

// File: rtl/mdio_dual_pkg.sv
package mdio_dual_pkg;

  typedef enum logic [3:0] {
    ST_PRE, ST_START, ST_OP1, ST_OP2, ST_HDR,
    ST_RTA1, ST_RTA2, ST_RDATA,
    ST_WTA1, ST_WTA2, ST_WDATA
  } frameState_t;

  typedef struct packed {
    logic shiftIn;
    logic captureHdr;
    logic readStrobe;
    logic loadRead;
    logic shiftOut;
    logic driveLow;
    logic driveData;
    logic commitWrite;
  } frameStrobe_t;

endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_dual_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32,
  parameter int HDR_BITS     = 10,
  parameter int DATA_W       = 16
) (
  input  logic         mdc,
  input  logic         rstN,
  input  logic         mdioIn,
  output frameStrobe_t strobe
);
  localparam int PRE_W = $clog2(PREAMBLE_LEN + 1);
  localparam int BIT_W = $clog2((DATA_W > HDR_BITS) ? DATA_W : HDR_BITS);
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;

  frameState_t state;
  logic [PRE_W-1:0] preCnt;
  logic [BIT_W-1:0] bitCnt;
  logic opHi;
  logic isRead;
  logic hdrLast;
  logic dataLast;

  assign hdrLast  = (bitCnt == BIT_W'(HDR_BITS - 1));
  assign dataLast = (bitCnt == BIT_W'(DATA_W - 1));

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_PRE;
      preCnt <= '0;
      bitCnt <= '0;
      opHi   <= 1'b0;
      isRead <= 1'b0;
    end else begin
      if (state != ST_PRE) preCnt <= '0;
      case (state)
        ST_PRE: begin
          if (mdioIn) begin
            if (preCnt != PRE_W'(PREAMBLE_LEN)) preCnt <= preCnt + 1'b1;
          end else if (preCnt == PRE_W'(PREAMBLE_LEN)) begin
            state  <= ST_START;
            preCnt <= '0;
          end else begin
            preCnt <= '0;
          end
        end
        ST_START: state <= mdioIn ? ST_OP1 : ST_PRE;
        ST_OP1: begin
          opHi  <= mdioIn;
          state <= ST_OP2;
        end
        ST_OP2: begin
          bitCnt <= '0;
          if ({opHi, mdioIn} == OP_READ) begin
            isRead <= 1'b1;
            state  <= ST_HDR;
          end else if ({opHi, mdioIn} == OP_WRITE) begin
            isRead <= 1'b0;
            state  <= ST_HDR;
          end else begin
            state <= ST_PRE;
          end
        end
        ST_HDR: begin
          if (hdrLast) begin
            bitCnt <= '0;
            state  <= isRead ? ST_RTA1 : ST_WTA1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_RTA1: state <= ST_RTA2;
        ST_RTA2: state <= ST_RDATA;
        ST_WTA1: state <= ST_WTA2;
        ST_WTA2: state <= ST_WDATA;
        ST_RDATA, ST_WDATA: begin
          if (dataLast) begin
            bitCnt <= '0;
            state  <= ST_PRE;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_PRE;
      endcase
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.shiftIn     = (state == ST_HDR) || (state == ST_WDATA);
    strobe.captureHdr  = (state == ST_HDR) && hdrLast;
    strobe.readStrobe  = (state == ST_RTA1);
    strobe.loadRead    = (state == ST_RTA1);
    strobe.driveLow    = (state == ST_RTA2);
    strobe.driveData   = (state == ST_RDATA);
    strobe.shiftOut    = (state == ST_RDATA);
    strobe.commitWrite = (state == ST_WDATA) && dataLast;
  end

endmodule

// File: rtl/mdio_reg_path.sv
module mdio_reg_path
  import mdio_dual_pkg::*;
#(
  parameter int PHY_W   = 5,
  parameter int REG_W   = 5,
  parameter int SEL_BIT = 2,
  parameter int DATA_W  = 16,
  parameter int BYTE_W  = 8
) (
  input  logic                           mdc,
  input  logic                           rstN,
  input  logic                           mdioIn,
  input  logic [1:0]                     strapSel,
  input  frameStrobe_t                   strobe,
  input  logic [DATA_W-1:0]              stdRdData,
  input  logic [BYTE_W-1:0]              byteRdData,
  output logic [PHY_W-SEL_BIT-1+REG_W-1:0] busAddr,
  output logic                           busSpace,
  output logic                           busRdEn,
  output logic                           busWrEn,
  output logic [DATA_W-1:0]              busWrData,
  output logic                           mdioOut,
  output logic                           mdioOe
);
  localparam int HDR_BITS = PHY_W + REG_W;
  localparam int HI_W     = PHY_W - SEL_BIT - 1;
  localparam int LO_W     = SEL_BIT;
  localparam int ADDR_W   = HI_W + REG_W;

  logic [DATA_W-1:0]   inShift;
  logic [DATA_W-1:0]   inWord;
  logic [HDR_BITS-1:0] hdrWord;
  logic [HI_W-1:0]     addrHi;
  logic [LO_W-1:0]     addrLo;
  logic [REG_W-1:0]    regQ;
  logic                spaceQ;
  logic [DATA_W-1:0]   rdShift;
  logic [DATA_W-1:0]   wrDataQ;
  logic                wrPulse;

  assign inWord  = {inShift[DATA_W-2:0], mdioIn};
  assign hdrWord = inWord[HDR_BITS-1:0];

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      inShift <= '0;
      addrHi  <= '0;
      addrLo  <= '0;
      regQ    <= '0;
      spaceQ  <= 1'b0;
      rdShift <= '0;
      wrDataQ <= '0;
      wrPulse <= 1'b0;
    end else begin
      wrPulse <= strobe.commitWrite;
      if (strobe.shiftIn) inShift <= inWord;
      if (strobe.captureHdr) begin
        addrHi <= hdrWord[HDR_BITS-1 -: HI_W];
        addrLo <= hdrWord[REG_W +: LO_W];
        regQ   <= hdrWord[REG_W-1:0];
        spaceQ <= (&strapSel) && hdrWord[REG_W + SEL_BIT];
      end
      if (strobe.loadRead)
        rdShift <= spaceQ ? {{(DATA_W-BYTE_W){1'b0}}, byteRdData} : stdRdData;
      else if (strobe.shiftOut)
        rdShift <= {rdShift[DATA_W-2:0], 1'b0};
      if (strobe.commitWrite)
        wrDataQ <= spaceQ ? {{(DATA_W-BYTE_W){1'b0}}, inWord[BYTE_W-1:0]} : inWord;
    end
  end

  assign busAddr   = spaceQ ? {addrHi, regQ} : ADDR_W'({addrLo, regQ});
  assign busSpace  = spaceQ;
  assign busRdEn   = strobe.readStrobe;
  assign busWrEn   = wrPulse;
  assign busWrData = wrDataQ;
  assign mdioOe    = strobe.driveLow || strobe.driveData;
  assign mdioOut   = strobe.driveData && rdShift[DATA_W-1];

endmodule

// File: rtl/mdio_dual_map_slave.sv
module mdio_dual_map_slave
  import mdio_dual_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32,
  parameter int PHY_W        = 5,
  parameter int REG_W        = 5,
  parameter int SEL_BIT      = 2,
  parameter int DATA_W       = 16,
  parameter int BYTE_W       = 8,
  localparam int ADDR_W      = PHY_W - SEL_BIT - 1 + REG_W
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic [1:0]        strapSel,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busSpace,
  output logic              busRdEn,
  output logic              busWrEn,
  output logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] stdRdData,
  input  logic [BYTE_W-1:0] byteRdData
);
  frameStrobe_t strobe;

  mdio_frame_ctrl #(
    .PREAMBLE_LEN(PREAMBLE_LEN),
    .HDR_BITS    (PHY_W + REG_W),
    .DATA_W      (DATA_W)
  ) ctrl (
    .mdc   (mdc),
    .rstN  (rstN),
    .mdioIn(mdioIn),
    .strobe(strobe)
  );

  mdio_reg_path #(
    .PHY_W  (PHY_W),
    .REG_W  (REG_W),
    .SEL_BIT(SEL_BIT),
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
  ) path (
    .mdc       (mdc),
    .rstN      (rstN),
    .mdioIn    (mdioIn),
    .strapSel  (strapSel),
    .strobe    (strobe),
    .stdRdData (stdRdData),
    .byteRdData(byteRdData),
    .busAddr   (busAddr),
    .busSpace  (busSpace),
    .busRdEn   (busRdEn),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe)
  );

endmodule

// File: rtl/mdio_dual_map_slave_chk.sv
module mdio_dual_map_slave_chk #(
  parameter int DATA_W = 16
) (
  input logic              mdc,
  input logic              rstN,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic [1:0]        strapSel,
  input logic              busSpace,
  input logic              busRdEn,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData
);
  AST_RD_STROBE_SINGLE: assert property (@(posedge mdc) disable iff (!rstN)
    busRdEn |=> !busRdEn); // R8
  AST_WR_STROBE_SINGLE: assert property (@(posedge mdc) disable iff (!rstN)
    busWrEn |=> !busWrEn); // R7
  AST_STROBES_EXCLUSIVE: assert property (@(posedge mdc) disable iff (!rstN)
    !(busRdEn && busWrEn)); // R8
  AST_TA_FIRST_RELEASED: assert property (@(posedge mdc) disable iff (!rstN)
    busRdEn |-> !mdioOe); // R2
  AST_TA_SECOND_LOW: assert property (@(posedge mdc) disable iff (!rstN)
    busRdEn |=> (mdioOe && !mdioOut)); // R2
  AST_DRIVE_AFTER_READ: assert property (@(posedge mdc) disable iff (!rstN)
    $rose(mdioOe) |-> $past(busRdEn)); // R2
  AST_BYTE_WRITE_HIGH_ZERO: assert property (@(posedge mdc) disable iff (!rstN)
    (busWrEn && busSpace) |-> (busWrData[DATA_W-1:8] == '0)); // R7
  AST_STRAP_GATES_BYTES: assert property (@(posedge mdc) disable iff (!rstN)
    (busRdEn && busSpace) |-> $past(&strapSel)); // R5
endmodule

bind mdio_dual_map_slave mdio_dual_map_slave_chk chk (
  .mdc      (mdc),
  .rstN     (rstN),
  .mdioOut  (mdioOut),
  .mdioOe   (mdioOe),
  .strapSel (strapSel),
  .busSpace (busSpace),
  .busRdEn  (busRdEn),
  .busWrEn  (busWrEn),
  .busWrData(busWrData)
);

// File: tb/mdio_dual_map_slave_test.sv
`timescale 1ns/1ps
module mdio_dual_map_slave_test;
  localparam int N = 2048;

  logic        mdc = 1'b0;
  logic        rstN;
  logic        mdioIn;
  logic        mdioOut, mdioOe;
  logic [1:0]  strapSel;
  logic [6:0]  busAddr;
  logic        busSpace, busRdEn, busWrEn;
  logic [15:0] busWrData, stdRdData;
  logic [7:0]  byteRdData;

  always #4 mdc = ~mdc;

  mdio_dual_map_slave uut (
    .mdc(mdc), .rstN(rstN), .mdioIn(mdioIn), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .strapSel(strapSel), .busAddr(busAddr), .busSpace(busSpace),
    .busRdEn(busRdEn), .busWrEn(busWrEn), .busWrData(busWrData),
    .stdRdData(stdRdData), .byteRdData(byteRdData)
  );

  function automatic logic [15:0] wordVal(input logic [6:0] a);
    return 16'hC35A ^ {a, 2'b01, a};
  endfunction
  function automatic logic [7:0] byteVal(input logic [6:0] a);
    return 8'h96 ^ {a, 1'b1};
  endfunction

  always_comb begin
    stdRdData  = wordVal(busAddr);
    byteRdData = byteVal(busAddr);
  end

  // behavioural schedule: stimulus and expected outputs per cycle
  logic        stim     [N];
  logic [1:0]  strapArr [N];
  logic        expOe    [N];
  logic        expOut   [N];
  logic        expRd    [N];
  logic        expWr    [N];
  logic [6:0]  expAddr  [N];
  logic        expSpace [N];
  logic [15:0] expData  [N];
  string       tagArr   [N];
  int cur = 0;
  int checks = 0;
  int errors = 0;
  string curTag = "R1";
  logic [1:0] curStrap = 2'b11;

  task automatic pushBit(input logic b);
    stim[cur] = b;
    strapArr[cur] = curStrap;
    tagArr[cur] = curTag;
    cur++;
  endtask

  task automatic pushBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pushBit(v[i]);
  endtask

  task automatic pushOnes(input int n);
    for (int i = 0; i < n; i++) pushBit(1'b1);
  endtask

  task automatic addFrame(input int preLen, input logic rd, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] wd,
                          input logic served, input string tag);
    int lastHdr;
    logic sp;
    logic [6:0] a;
    logic [15:0] d;
    curTag = tag;
    pushBit(1'b0);
    pushOnes(preLen);
    pushBits({2'b01, rd ? 2'b10 : 2'b01}, 4);
    pushBits(phy, 5);
    pushBits(rg, 5);
    lastHdr = cur - 1;
    if (rd) pushOnes(18);
    else begin
      pushBits(2'b10, 2);
      pushBits(wd, 16);
    end
    if (!served) return;
    sp = (curStrap == 2'b11) && phy[2];
    a  = sp ? {phy[4:3], rg} : {phy[1:0], rg};
    if (rd) begin
      d = sp ? {8'h00, byteVal(a)} : wordVal(a);
      expRd[lastHdr] = 1'b1;
      expAddr[lastHdr] = a;
      expSpace[lastHdr] = sp;
      for (int i = 1; i <= 17; i++) expOe[lastHdr + i] = 1'b1;
      expOut[lastHdr + 1] = 1'b0;
      for (int i = 0; i < 16; i++) expOut[lastHdr + 2 + i] = d[15 - i];
    end else begin
      expWr[lastHdr + 18] = 1'b1;
      expAddr[lastHdr + 18] = a;
      expSpace[lastHdr + 18] = sp;
      expData[lastHdr + 18] = sp ? {8'h00, wd[7:0]} : wd;
    end
  endtask

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [15:0] got, input logic [15:0] exp, input int k);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d %s got %h expected %h", tag, k, what, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge mdc);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      stim[i] = 1'b1; strapArr[i] = 2'b11; expOe[i] = 1'b0; expOut[i] = 1'b0;
      expRd[i] = 1'b0; expWr[i] = 1'b0; expAddr[i] = '0; expSpace[i] = 1'b0;
      expData[i] = '0; tagArr[i] = "R1";
    end
    // R3: word read, PHY bits 4:3 set but ignored
    addFrame(32, 1'b1, 5'b11010, 5'h13, 16'h0, 1'b1, "R3");
    // R4 and R6: byte read, PHY bits 1:0 ignored
    addFrame(32, 1'b1, 5'b10101, 5'h0A, 16'h0, 1'b1, "R6");
    // R2: longer preamble, read with MSB pattern
    addFrame(40, 1'b1, 5'b00011, 5'h1F, 16'h0, 1'b1, "R2");
    // R7: byte write, high byte dropped
    addFrame(32, 1'b0, 5'b01111, 5'h1F, 16'hBEEF, 1'b1, "R7");
    // R7: word write keeps all 16 bits
    addFrame(32, 1'b0, 5'b00001, 5'h02, 16'h1234, 1'b1, "R7");
    // R5: straps not both high, bit 2 set still reaches word space
    curStrap = 2'b10;
    addFrame(32, 1'b1, 5'b11101, 5'h05, 16'h0, 1'b1, "R5");
    curStrap = 2'b01;
    addFrame(32, 1'b0, 5'b10110, 5'h11, 16'hA5C3, 1'b1, "R5");
    curStrap = 2'b11;
    // R1: 31 ones only, write ignored
    addFrame(31, 1'b0, 5'b00100, 5'h01, 16'h5555, 1'b0, "R1");
    // R1: exactly 32 ones served again
    addFrame(32, 1'b1, 5'b00100, 5'h01, 16'h0, 1'b1, "R1");
    // R9: opcode 11 aborts, following frame without preamble ignored
    curTag = "R9";
    pushBit(1'b0);
    pushOnes(32);
    pushBits(4'b0111, 4);
    pushBits(14'b01_10_00000_00110, 14);
    pushOnes(18);
    // R9: opcode 00 aborts
    pushBit(1'b0);
    pushOnes(32);
    pushBits(4'b0100, 4);
    pushBits(12'b0000_0001_0000, 12);
    addFrame(32, 1'b0, 5'b00010, 5'h07, 16'h0F0F, 1'b1, "R9");
    addFrame(32, 1'b1, 5'b00010, 5'h07, 16'h0, 1'b1, "R8");
    pushOnes(4);

    rstN = 1'b0; mdioIn = 1'b1; strapSel = 2'b11;
    repeat (3) @(negedge mdc);
    chk(mdioOe == 1'b0, "R10", "mdioOe", {15'd0, mdioOe}, 16'd0, -1);
    chk(busRdEn == 1'b0 && busWrEn == 1'b0, "R10", "strobes",
        {14'd0, busRdEn, busWrEn}, 16'd0, -1);
    rstN = 1'b1;
    for (int k = 0; k < cur; k++) begin
      mdioIn = stim[k];
      strapSel = strapArr[k];
      @(posedge mdc);
      @(negedge mdc);
      chk(mdioOe == expOe[k], tagArr[k], "mdioOe", {15'd0, mdioOe}, {15'd0, expOe[k]}, k);
      if (expOe[k])
        chk(mdioOut == expOut[k], tagArr[k], "mdioOut", {15'd0, mdioOut}, {15'd0, expOut[k]}, k);
      chk(busRdEn == expRd[k], tagArr[k], "busRdEn", {15'd0, busRdEn}, {15'd0, expRd[k]}, k);
      chk(busWrEn == expWr[k], tagArr[k], "busWrEn", {15'd0, busWrEn}, {15'd0, expWr[k]}, k);
      if (expRd[k] || expWr[k]) begin
        chk(busAddr == expAddr[k], tagArr[k], "busAddr", {9'd0, busAddr}, {9'd0, expAddr[k]}, k);
        chk(busSpace == expSpace[k], tagArr[k], "busSpace", {15'd0, busSpace},
            {15'd0, expSpace[k]}, k);
      end
      if (expWr[k])
        chk(busWrData == expData[k], tagArr[k], "busWrData", busWrData, expData[k], k);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule